// File: doc/BRIEF.md
# Pipelined-Write Flow-Through Synchronous SRAM

This block models a small on-chip synchronous SRAM that needs no idle cycle when reads and writes alternate. A command (address, direction, chip selects, burst control) is taken on a rising clock edge. Read data comes straight out of the array, with no output register, in the cycle that follows the edge that accepted the read. Write data and its per-lane strobes come one enabled edge after the write address. A read can therefore be accepted on the same edge that completes the previous write.

Each data lane holds eight data bits and one parity bit, and all nine bits are handled together. A two-bit burst counter lets a sequence continue without a new address, in linear or interleaved order selected by a strap input. An active-low clock enable stalls the whole device. A sleep input blocks new accesses and keeps the stored contents. The data bus is split into separate input and output vectors with a drive-enable output, so a pad ring or a wrapper can build the tri-state pin.

Top module: `fts_sram`

## Requirements
- R1: After synchronous reset the drive enable is low, no burst is active, and every location reads back as all zeros.
- R2: A command with advance/load low is accepted only when sel1_n is 0, sel2 is 1 and sel3_n is 0 on the same edge. Any other combination deselects the device: no write takes place and the drive enable is low in the following cycle.
- R3: During the cycle after an edge that accepted a read, data_out shows the stored word at the read address, without waiting for a further clock edge. data_oe is high in that cycle if out_en_n is low.
- R4: A write address is taken on one enabled edge. On the next enabled edge, data_in and lane_wr_n are captured. Lane i (bits 9*i+8 down to 9*i, where bit 9*i+8 is that lane's parity bit) is written only when lane_wr_n[i] is 0.
- R5: A read accepted on the same edge that completes a write to the same address returns the lanes just written and the old contents of the other lanes.
- R6: During the write data cycle (the cycle after a write was accepted) data_oe is low, whatever out_en_n is.
- R7: While out_en_n is high, data_oe is low. This gating acts at once, without a clock edge.
- R8: While clk_en_n is high, clock edges have no effect. The current operation, the burst position and any pending write data phase are all held, and data_out stays stable.
- R9: With advance/load high on an enabled edge during an active operation, the previous operation continues at the next burst address. Only the two low address bits change. When burst_ilv is 0 they are (start + n) mod 4; when burst_ilv is 1 they are start XOR n, where n counts the advances since the load.
- R10: Advance/load high on an enabled edge while the device is idle or deselected leaves it deselected.
- R11: An enabled edge with sleep high starts no access, and the device is idle afterwards. A write data phase that falls on such an edge still completes, and stored data is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock qualifier; high stalls the device |
| addr | input | ADDR_W | Word address |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low starts a write, high a read, on a load cycle |
| lane_wr_n | input | LANES | Active-low lane strobes, taken in the write data cycle |
| adv_load | input | 1 | Low loads a new address, high advances the burst |
| burst_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| sleep | input | 1 | Active-high sleep; blocks new accesses |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| data_in | input | LANES*LANE_W | Write data from the bus |
| data_out | output | LANES*LANE_W | Flow-through read data |
| data_oe | output | 1 | High when the bus should be driven with data_out |

## Verification
A wrong operation register or burst position shows up in the very next cycle. The drive enable then rises when it should stay low, for example in a write data cycle or after a deselect, or data_out shows the word from a neighbouring address. A write that goes to the wrong edge or the wrong lanes stays hidden until that location is read back. For that reason the bench follows every write with a read, often on the same edge that completes the write. A stall that leaks a state change shows up as a moved output or a lost write right after clk_en_n is released.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Decoded command for one enabled edge
    typedef struct packed {
        logic load;
        logic adv;
        op_e  op_next;
    } cmd_t;

    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step_cnt,
        input logic               ilv
    );
        return ilv ? (start ^ step_cnt) : (start + step_cnt);
    endfunction

    function automatic logic chips_on(input logic s1n, input logic s2, input logic s3n);
        return !s1n && s2 && !s3n;
    endfunction

endpackage

// File: rtl/fts_burst.sv
module fts_burst
    import fts_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_cur
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign addr_cur = {base_q[ADDR_W-1:BURST_W],
                       burst_low(base_q[BURST_W-1:0], cnt_q, ilv)};

endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic chips,
    input  logic sleep,
    input  logic wr_n,
    input  logic adv_load,
    output cmd_t cmd,
    output op_e  op_q,
    output logic commit
);

    always_comb begin
        cmd         = '0;
        cmd.op_next = op_q;
        if (step) begin
            if (!adv_load) begin
                if (chips && !sleep) begin
                    cmd.load    = 1'b1;
                    cmd.op_next = wr_n ? OP_READ : OP_WRITE;
                end else begin
                    cmd.op_next = OP_IDLE;
                end
            end else if (op_q != OP_IDLE && !sleep) begin
                cmd.adv = 1'b1;
            end else begin
                cmd.op_next = OP_IDLE;
            end
        end
    end

    // The cycle after an accepted write is its data phase
    assign commit = step && (op_q == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) op_q <= OP_IDLE;
        else     op_q <= cmd.op_next;
    end

endmodule

// File: rtl/fts_array.sv
module fts_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && !lane_n[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    adv_load,
    input  logic                    burst_ilv,
    input  logic                    sleep,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] data_in,
    output logic [LANES*LANE_W-1:0] data_out,
    output logic                    data_oe
);

    localparam int DATA_W = LANES * LANE_W;

    logic              step;
    logic              chips;
    cmd_t              cmd;
    op_e               op_q;
    logic              commit;
    logic [ADDR_W-1:0] addr_cur;

    assign step  = !clk_en_n;
    assign chips = chips_on(sel1_n, sel2, sel3_n);

    fts_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .chips    (chips),
        .sleep    (sleep),
        .wr_n     (wr_n),
        .adv_load (adv_load),
        .cmd      (cmd),
        .op_q     (op_q),
        .commit   (commit)
    );

    fts_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load),
        .adv      (cmd.adv),
        .ilv      (burst_ilv),
        .addr_in  (addr),
        .addr_cur (addr_cur)
    );

    // The current address is the write target during a data phase and
    // the read address during a read cycle.
    fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .we     (commit),
        .lane_n (lane_wr_n),
        .addr   (addr_cur),
        .wdata  (data_in),
        .rdata  (data_out)
    );

    assign data_oe = !out_en_n && (op_q == OP_READ);

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk (
    input logic        clk,
    input logic        rst,
    input logic        clk_en_n,
    input logic        sel1_n,
    input logic        sel2,
    input logic        sel3_n,
    input logic        wr_n,
    input logic        adv_load,
    input logic        sleep,
    input logic [35:0] data_out,
    input logic        data_oe
);

    logic chips;
    assign chips = !sel1_n && sel2 && !sel3_n;

    // R6
    write_phase_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && chips && !adv_load && !wr_n && !sleep) |=> !data_oe);

    // R2
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !adv_load && !chips) |=> !data_oe);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(data_out));

    // R11
    sleep_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && sleep) |=> !data_oe);

endmodule

bind fts_sram fts_sram_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .wr_n     (wr_n),
    .adv_load (adv_load),
    .sleep    (sleep),
    .data_out (data_out),
    .data_oe  (data_oe)
);

// File: tb/fts_sram_tb.sv
module fts_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [3:0]  lane_wr_n = '1;
    logic        adv_load = 1'b0;
    logic        burst_ilv = 1'b0;
    logic        sleep = 1'b0;
    logic        out_en_n = 1'b0;
    logic [35:0] data_in = '0;
    logic [35:0] data_out;
    logic        data_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fts_sram dut_i (.*);

    // Behavioural reference: 0 idle, 1 read, 2 write
    logic [35:0] m_mem [16];
    int          m_op = 0;
    logic [3:0]  m_base = '0;
    int          m_cnt = 0;

    function automatic logic [3:0] m_addr();
        logic [1:0] lo;
        lo = burst_ilv ? (m_base[1:0] ^ 2'(m_cnt)) : 2'(m_base[1:0] + 2'(m_cnt));
        return {m_base[3:2], lo};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        logic [3:0] wa;
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 16; i++) m_mem[i] = '0;
            m_op = 0; m_base = '0; m_cnt = 0;
        end else if (!clk_en_n) begin
            if (m_op == 2) begin
                wa = m_addr();
                for (int l = 0; l < 4; l++)
                    if (!lane_wr_n[l]) m_mem[wa][l*9 +: 9] = data_in[l*9 +: 9];
            end
            if (!adv_load) begin
                if (!sel1_n && sel2 && !sel3_n && !sleep) begin
                    m_base = addr; m_cnt = 0; m_op = wr_n ? 1 : 2;
                end else m_op = 0;
            end else if (m_op != 0 && !sleep) m_cnt = (m_cnt + 1) % 4;
            else m_op = 0;
        end
        #2;
        check({tag, " oe"}, 36'(data_oe), 36'(!out_en_n && m_op == 1));
        if (!out_en_n && m_op == 1) check({tag, " data"}, data_out, m_mem[m_addr()]);
        @(negedge clk);
    endtask

    // adv, wr, address, data for the pending write phase, lane strobes
    task automatic op(input bit adv, input bit wr, input logic [3:0] a,
                      input logic [35:0] d, input logic [3:0] ln, input string tag);
        adv_load = adv; wr_n = !wr; addr = a; data_in = d; lane_wr_n = ln;
        tick(tag);
    endtask

    initial begin
        @(negedge clk);
        tick("R1 reset");
        tick("R1 reset");
        rst = 1'b0;
        op(0, 0, 4'd5, '0, 4'hF, "R1 read zero");
        op(0, 0, 4'd5, '0, 4'hF, "R3 read");
        // write then same-edge read
        op(0, 1, 4'd3, '0, 4'hF, "R6 write addr");
        out_en_n = 1'b0;
        op(0, 0, 4'd3, 36'h1_2345_6789, 4'h0, "R5 read after write");
        op(0, 1, 4'd3, '0, 4'hF, "R6 write addr");
        op(0, 0, 4'd3, 36'hF_EDCB_A987, 4'b1010, "R4 partial lanes");
        op(0, 1, 4'd7, '0, 4'hF, "R4 write");
        op(0, 0, 4'd7, 36'h8_0402_0100, 4'h0, "R4 parity bits");
        // deselect combinations
        sel1_n = 1'b1; op(0, 0, 4'd3, '0, 4'hF, "R2 sel1");
        sel1_n = 1'b0; sel2 = 1'b0; op(0, 1, 4'd3, '0, 4'hF, "R2 sel2 write");
        sel2 = 1'b1;
        op(0, 0, 4'd3, 36'hA_AAAA_AAAA, 4'h0, "R2 no write");
        sel3_n = 1'b1; op(0, 0, 4'd3, '0, 4'hF, "R2 sel3");
        op(1, 0, 4'd3, '0, 4'hF, "R10 adv while deselected");
        sel3_n = 1'b0;
        op(1, 0, 4'd3, '0, 4'hF, "R10 adv while idle");
        // linear write burst from 9: 9,10,11,8
        op(0, 1, 4'd9, '0, 4'hF, "R9 burst write");
        op(1, 1, 4'd0, 36'h0_0000_0009, 4'h0, "R9 burst write");
        op(1, 1, 4'd0, 36'h0_0000_000A, 4'h0, "R9 burst write");
        op(1, 1, 4'd0, 36'h0_0000_000B, 4'h0, "R9 burst write");
        op(0, 0, 4'd8, 36'h0_0000_0008, 4'h0, "R9 linear read");
        op(1, 0, 4'd0, '0, 4'hF, "R9 linear read");
        op(1, 0, 4'd0, '0, 4'hF, "R9 linear read");
        op(1, 0, 4'd0, '0, 4'hF, "R9 linear read");
        op(1, 0, 4'd0, '0, 4'hF, "R9 linear wrap");
        burst_ilv = 1'b1;
        op(0, 0, 4'd10, '0, 4'hF, "R9 interleaved read");
        op(1, 0, 4'd0, '0, 4'hF, "R9 interleaved read");
        op(1, 0, 4'd0, '0, 4'hF, "R9 interleaved read");
        op(1, 0, 4'd0, '0, 4'hF, "R9 interleaved read");
        burst_ilv = 1'b0;
        // stall during a read and during a write data phase
        op(0, 0, 4'd3, '0, 4'hF, "R3 read");
        clk_en_n = 1'b1;
        op(0, 1, 4'd12, 36'h5_5555_5555, 4'h0, "R8 stall read");
        op(1, 0, 4'd7, '0, 4'h0, "R8 stall read");
        clk_en_n = 1'b0;
        op(0, 1, 4'd12, '0, 4'hF, "R8 write addr");
        clk_en_n = 1'b1;
        op(0, 0, 4'd3, 36'h0_DEAD_0000, 4'h0, "R8 stall data phase");
        clk_en_n = 1'b0;
        op(0, 0, 4'd12, 36'h3_1415_9265, 4'h0, "R8 resume write");
        // sleep
        sleep = 1'b1;
        op(0, 1, 4'd13, '0, 4'hF, "R11 sleep load");
        sleep = 1'b0;
        op(0, 0, 4'd13, 36'h7_7777_7777, 4'h0, "R11 no write");
        op(0, 1, 4'd13, '0, 4'hF, "R11 write addr");
        sleep = 1'b1;
        op(0, 0, 4'd13, 36'h2_7182_8182, 4'h0, "R11 sleep data phase");
        sleep = 1'b0;
        op(0, 0, 4'd13, '0, 4'hF, "R11 data kept");
        // asynchronous output enable
        #1 out_en_n = 1'b1;
        #1 check("R7 oe gated", 36'(data_oe), 36'd0);
        #1 out_en_n = 1'b0;
        #1 check("R7 oe restored", 36'(data_oe), 36'd1);
        @(negedge clk);
        out_en_n = 1'b1;
        op(0, 0, 4'd3, '0, 4'hF, "R7 read masked");
        out_en_n = 1'b0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule